// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block computes one arithmetic or logical operation on two 32-bit operands and records the result together with six status bits: carry, signed overflow, sign, zero, nibble carry and parity. The operation is one of add, subtract, bitwise AND, bitwise OR or bitwise XOR. A size select chooses whether the operands are treated as 8-bit, 16-bit or 32-bit values. Every flag is then taken from the bit positions that belong to that width.

The unit is registered. A valid operation presented on a rising clock edge updates the result and all six flags, and they appear one cycle later. When no valid operation is presented, the outputs keep their values. The unit also keeps its outputs when the operation code is unused. This lets the surrounding datapath treat the outputs as a status register that changes only when an instruction writes it.

Top module: `aflg_top`

## Requirements
- R1: While `rst_n` is low, `res_out` and all six flag outputs are 0.
- R2: When `in_valid` is 1 and `op_sel` is 0 (add), 1 (subtract a minus b), 2 (AND), 3 (OR) or 4 (XOR), `res_out` shows the operation on the low W bits of the operands one clock later, with the bits above W cleared. W is 8 for `size_sel` 0, 16 for `size_sel` 1, and 32 for `size_sel` 2 or 3.
- R3: `carry_o` is set after an add whose unsigned sum does not fit in W bits, and after a subtract where a is below b as W-bit unsigned values (a borrow).
- R4: `ovfl_o` is set after an add or a subtract whose true signed result, with the operands read as W-bit two's complement, lies outside the W-bit signed range.
- R5: `neg_o` equals bit W-1 of the recorded result. `zero_o` is 1 exactly when all W bits of the result are 0.
- R6: `nib_o` is set after an add whose low nibbles carry out of bit 3 into bit 4, and after a subtract where the low nibble of a is below that of b.
- R7: `par_o` is 1 when bits 7:0 of the result hold an even number of ones, at every W.
- R8: After a logical operation (`op_sel` 2, 3 or 4), `carry_o`, `ovfl_o` and `nib_o` are 0.
- R9: The result and the flags keep their previous values in two cases: when `in_valid` is 0, and when `op_sel` is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR |
| size_sel | input | 2 | Operand width: 0 8-bit, 1 16-bit, 2 or 3 32-bit |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| res_out | output | 32 | Recorded result, cleared above the selected width |
| carry_o | output | 1 | Unsigned carry or borrow |
| ovfl_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Sign of the result |
| zero_o | output | 1 | Result is zero |
| nib_o | output | 1 | Carry or borrow between bit 3 and bit 4 |
| par_o | output | 1 | Even parity of the low result byte |

## Verification
Several flags often fall in the same cycle. Carry and signed overflow both fire when 0x80 is added to 0x80 at 8 bits, and nibble carry and full carry both fire when 1 is added to all ones. Directed cases force these pairs together, and a behavioural model in the bench judges each flag separately, using integer arithmetic on the values of the selected width. The same operand bits are also sent at different sizes, and random traffic that mixes idle cycles and unused operation codes checks that a hold cycle and a new operation never mix.

// File: rtl/aflg_pkg.sv
package aflg_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } aflg_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } aflg_flags_t;

  // even number of ones in a byte gives 1
  function automatic logic parity_even8(input logic [7:0] v);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < 8; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  function automatic logic op_is_logical(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

endpackage

// File: rtl/aflg_addsub.sv
module aflg_addsub #(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int DATA_W   = BASE_W << (NUM_SIZES - 1)
) (
  input  logic [DATA_W-1:0]    a_in,
  input  logic [DATA_W-1:0]    b_in,
  input  logic                 do_sub,
  output logic [DATA_W-1:0]    sum_out,
  output logic [NUM_SIZES-1:0] carry_w,
  output logic [NUM_SIZES-1:0] ovfl_w,
  output logic                 nib_carry
);
  // subtract as a + ~b + 1; a borrow is the inverse of the carry out
  logic [DATA_W-1:0] b_eff;
  logic [4:0]        nib_sum;

  assign b_eff     = do_sub ? ~b_in : b_in;
  assign nib_sum   = {1'b0, a_in[3:0]} + {1'b0, b_eff[3:0]} + 5'(do_sub);
  assign nib_carry = nib_sum[4] ^ do_sub;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int W = BASE_W << g;
    logic [W:0] ext;
    assign ext        = {1'b0, a_in[W-1:0]} + {1'b0, b_eff[W-1:0]} + (W+1)'(do_sub);
    assign carry_w[g] = ext[W] ^ do_sub;
    assign ovfl_w[g]  = (a_in[W-1] == b_eff[W-1]) && (ext[W-1] != a_in[W-1]);
    if (g == NUM_SIZES - 1) begin : g_full
      assign sum_out = ext[W-1:0];
    end
  end

endmodule

// File: rtl/aflg_logic.sv
module aflg_logic #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] y_out
);
  import aflg_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  y_out = a_in & b_in;
      OP_OR:   y_out = a_in | b_in;
      OP_XOR:  y_out = a_in ^ b_in;
      default: y_out = '0;
    endcase
  end

endmodule

// File: rtl/aflg_flagsel.sv
module aflg_flagsel #(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int DATA_W   = BASE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input  logic [DATA_W-1:0]    raw_res,
  input  logic [SZ_W-1:0]      sz_idx,
  input  logic                 arith,
  input  logic [NUM_SIZES-1:0] carry_w,
  input  logic [NUM_SIZES-1:0] ovfl_w,
  input  logic                 nib_carry,
  output logic [DATA_W-1:0]    res_sized,
  output aflg_pkg::aflg_flags_t flags_nxt
);
  import aflg_pkg::*;

  logic [DATA_W-1:0]    trimmed [NUM_SIZES];
  logic [NUM_SIZES-1:0] top_bit;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    localparam int W = BASE_W << g;
    assign trimmed[g] = DATA_W'(raw_res[W-1:0]);
    assign top_bit[g] = raw_res[W-1];
  end

  always_comb begin
    res_sized    = trimmed[sz_idx];
    flags_nxt.sf = top_bit[sz_idx];
    flags_nxt.zf = (res_sized == '0);
    flags_nxt.pf = parity_even8(res_sized[7:0]);
    flags_nxt.cf = arith & carry_w[sz_idx];
    flags_nxt.of = arith & ovfl_w[sz_idx];
    flags_nxt.af = arith & nib_carry;
  end

endmodule

// File: rtl/aflg_top.sv
module aflg_top #(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int DATA_W   = BASE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [SZ_W-1:0]   size_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res_out,
  output logic              carry_o,
  output logic              ovfl_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              nib_o,
  output logic              par_o
);
  import aflg_pkg::*;

  // named events used by the assertions
  logic                 op_known;
  logic                 op_logic;
  logic                 upd_fire;
  logic [SZ_W-1:0]      sz_idx;
  logic [DATA_W-1:0]    sum_w;
  logic [DATA_W-1:0]    logic_w;
  logic [DATA_W-1:0]    raw_res;
  logic [DATA_W-1:0]    res_nxt;
  logic [NUM_SIZES-1:0] carry_w;
  logic [NUM_SIZES-1:0] ovfl_w;
  logic                 nib_carry;
  aflg_flags_t          flags_nxt;
  aflg_flags_t          flags_q;
  logic [DATA_W-1:0]    res_q;
  logic                 a_top;
  logic                 b_top;

  assign op_known = op_is_known(op_sel);
  assign op_logic = op_is_logical(op_sel);
  assign upd_fire = in_valid & op_known;
  assign sz_idx   = (size_sel > SZ_W'(NUM_SIZES - 1)) ? SZ_W'(NUM_SIZES - 1) : size_sel;

  aflg_addsub #(.BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES)) u_addsub (
    .a_in      (opnd_a),
    .b_in      (opnd_b),
    .do_sub    (op_sel == OP_SUB),
    .sum_out   (sum_w),
    .carry_w   (carry_w),
    .ovfl_w    (ovfl_w),
    .nib_carry (nib_carry)
  );

  aflg_logic #(.DATA_W(DATA_W)) u_logic (
    .op    (op_sel),
    .a_in  (opnd_a),
    .b_in  (opnd_b),
    .y_out (logic_w)
  );

  assign raw_res = op_logic ? logic_w : sum_w;

  aflg_flagsel #(.BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES)) u_flagsel (
    .raw_res   (raw_res),
    .sz_idx    (sz_idx),
    .arith     (~op_logic),
    .carry_w   (carry_w),
    .ovfl_w    (ovfl_w),
    .nib_carry (nib_carry),
    .res_sized (res_nxt),
    .flags_nxt (flags_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (upd_fire) begin
      res_q   <= res_nxt;
      flags_q <= flags_nxt;
    end
  end

  assign res_out = res_q;
  assign carry_o = flags_q.cf;
  assign ovfl_o  = flags_q.of;
  assign neg_o   = flags_q.sf;
  assign zero_o  = flags_q.zf;
  assign nib_o   = flags_q.af;
  assign par_o   = flags_q.pf;

  // operand sign bits at the selected width, for the overflow check
  always_comb begin
    a_top = 1'b0;
    b_top = 1'b0;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (g == int'(sz_idx)) begin
        a_top = opnd_a[(BASE_W << g) - 1];
        b_top = opnd_b[(BASE_W << g) - 1];
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> ($stable(res_q) && $stable(flags_q)));

  assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && op_logic) |=> (!carry_o && !ovfl_o && !nib_o));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && op_sel == OP_ADD && a_top != b_top) |=> !ovfl_o);

  assert_equal_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && op_sel == OP_SUB && opnd_a == opnd_b) |=> (!carry_o && zero_o));

  assert_nibble_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && op_sel == OP_ADD && opnd_a[3:0] == 4'd0) |=> !nib_o);

  assert_zero_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (res_out == '0 && !neg_o));

  assert_zero_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> par_o);

endmodule

// File: tb/test_aflg_top.sv
`timescale 1ns/1ps
module test_aflg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  size_sel = 2'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] res_out;
  logic        carry_o, ovfl_o, neg_o, zero_o, nib_o, par_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  bit cmp_on   = 1'b0;

  // model state: {res, cf, of, sf, zf, af, pf}
  logic [37:0] m_state = '0;

  always #2 clk = ~clk;

  aflg_top i_aflg_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .size_sel(size_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .res_out(res_out),
    .carry_o(carry_o), .ovfl_o(ovfl_o), .neg_o(neg_o), .zero_o(zero_o),
    .nib_o(nib_o), .par_o(par_o)
  );

  function automatic logic [37:0] model(input logic [2:0] op, input logic [1:0] sz,
                                        input logic [31:0] a, input logic [31:0] b);
    int w; longint m, half, ua, ub, sa, sb, r, sr; bit cf, of, af, sf, zf, pf; int ones;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    ua = longint'(a) & m;
    ub = longint'(b) & m;
    sa = (ua >= half) ? ua - 2 * half : ua;
    sb = (ub >= half) ? ub - 2 * half : ub;
    cf = 0; of = 0; af = 0; sr = 0;
    case (op)
      3'd0: begin r = ua + ub; cf = r > m; sr = sa + sb; af = ((ua & 15) + (ub & 15)) > 15; end
      3'd1: begin r = ua - ub; cf = ua < ub; sr = sa - sb; af = (ua & 15) < (ub & 15); end
      3'd2: r = ua & ub;
      3'd3: r = ua | ub;
      default: r = ua ^ ub;
    endcase
    if (op < 3'd2) of = (sr >= half) || (sr < -half);
    r = r & m;
    sf = ((r >> (w - 1)) & 1) != 0;
    zf = (r == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) if (((r >> i) & 1) != 0) ones++;
    pf = (ones % 2) == 0;
    return {r[31:0], cf, of, sf, zf, af, pf};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_state = '0;
    else if (in_valid && op_sel <= 3'd4) m_state = model(op_sel, size_sel, opnd_a, opnd_b);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [37:0] dut_state();
    return {res_out, carry_o, ovfl_o, neg_o, zero_o, nib_o, par_o};
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 result", res_out, m_state[37:6]);
      chk("R3 carry", 32'(carry_o), 32'(m_state[5]));
      chk("R4 overflow", 32'(ovfl_o), 32'(m_state[4]));
      chk("R5 sign", 32'(neg_o), 32'(m_state[3]));
      chk("R5 zero", 32'(zero_o), 32'(m_state[2]));
      chk("R6 nibble", 32'(nib_o), 32'(m_state[1]));
      chk("R7 parity", 32'(par_o), 32'(m_state[0]));
    end
  end

  task automatic apply(input bit v, input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = v; op_sel = op; size_sel = sz; opnd_a = a; opnd_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_state(input string tag, input logic [37:0] exp);
    n_checks++;
    if (dut_state() !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, dut_state(), exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [37:0] held;
    // R1: reset holds everything at zero even with a valid operation present
    in_valid = 1'b1; op_sel = 3'd0; opnd_a = 32'hFF; opnd_b = 32'h01;
    repeat (3) @(posedge clk);
    #1;
    expect_state("R1 reset state", 38'd0);
    @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b0;
    cmp_on = 1'b1;

    apply(1, 3'd0, 2'd0, 32'h80, 32'h80);
    expect_state("R3 R4 carry and overflow together", {32'h0, 6'b110101});
    apply(1, 3'd0, 2'd0, 32'h7F, 32'h01);
    expect_state("R4 R6 signed overflow with nibble carry", {32'h80, 6'b011010});
    apply(1, 3'd1, 2'd1, 32'h0, 32'h1);
    expect_state("R3 borrow at 16 bits", {32'h0000FFFF, 6'b101011});
    apply(1, 3'd0, 2'd2, 32'hFFFFFFFF, 32'h1);
    expect_state("R3 R6 carry and nibble at 32 bits", {32'h0, 6'b100111});
    apply(1, 3'd0, 2'd0, 32'h1FF, 32'h1);
    expect_state("R2 upper bits ignored at 8 bits", {32'h0, 6'b100111});
    apply(1, 3'd0, 2'd3, 32'h7FFFFFFF, 32'h1);
    expect_state("R4 size 3 acts as 32 bits", {32'h80000000, 6'b011011});
    apply(1, 3'd4, 2'd2, 32'h12345678, 32'h12345678);
    expect_state("R8 xor clears arithmetic flags", {32'h0, 6'b000101});
    apply(1, 3'd1, 2'd0, 32'h80, 32'h01);
    expect_state("R4 R6 subtract overflow at 8 bits", {32'h7F, 6'b010010});
    held = dut_state();
    apply(0, 3'd0, 2'd0, 32'h0, 32'h0);
    expect_state("R9 idle cycle holds", held);
    apply(1, 3'd6, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
    expect_state("R9 unused op code holds", held);
    apply(1, 3'd3, 2'd1, 32'hF0F0_0F00, 32'h0000_80F0);
    expect_state("R8 R5 R7 or at 16 bits", {32'h00008FF0, 6'b001001});

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (($urandom % 8) == 0) rb = ra;
      if (($urandom % 8) == 0) ra = 32'h80000000 >> (($urandom % 4) * 8);
      apply(($urandom % 4) != 0, 3'($urandom % 8), 2'($urandom % 4), ra, rb);
    end

    @(negedge clk);
    cmp_on = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule